// File: doc/BRIEF.md
# Shared Serial Port Pin Function Controller

This block controls an eight-pin port that one SPI engine and two SCI (UART-style) channels share with general-purpose I/O. An 8-bit direction register sets, pin by pin, whether the pin is plain GPIO or carries a peripheral signal, and which way that signal flows. The live SPI mode (master or slave), the SPI enable, and the receiver and transmitter enables of each SCI channel also take part in the decision. From these the block drives a per-pin pad output enable and output value. It steers pad levels to the SPI and SCI receive inputs. It also holds a GPIO data latch and a sticky SPI mode-fault flag.

Software reaches two 16-bit bus slots through a simple synchronous write port with byte strobes. Only the low byte of each slot is implemented. `bus_sel` = 0 selects the direction register and `bus_sel` = 1 selects the GPIO data latch. Reads are combinational. The SPI and SCI engines sit outside the block and connect through the `spi_*` and `sci_*` ports.

Pin order, LSB first: bit 0 MISO, bit 1 MOSI, bit 2 SCK, bit 3 slave-select (active low), bit 4 SCI-B receive, bit 5 SCI-B transmit, bit 6 SCI-A receive, bit 7 SCI-A transmit.

Top module: `shared_port_mux`

## Requirements
- R1: After reset, the direction register and the data latch read 0, every `pad_oe` bit is 0, and `mode_fault` is 0.
- R2: A write with `bus_we`=1 and `bus_be[0]`=1 loads `bus_wdata[7:0]` into the slot chosen by `bus_sel`. A write through `bus_be[1]` alone changes nothing. `bus_rdata[15:8]` always reads 0.
- R3: MISO with the SPI enabled:
  - Master mode: the pad is never driven. `spi_miso_in` follows pad 0 when direction bit 0 is 0 and is held at 0 when it is 1.
  - Slave mode: pad 0 drives `spi_miso_out` when bit 0 is 1 and is undriven when bit 0 is 0. `spi_miso_in` is 0.
- R4: MOSI with the SPI enabled:
  - Master mode: pad 1 drives `spi_mosi_out` when bit 1 is 1 and is undriven when bit 1 is 0. `spi_mosi_in` is 0.
  - Slave mode: pad 1 is undriven. `spi_mosi_in` follows pad 1 when bit 1 is 0 and is 0 when bit 1 is 1.
- R5: SCK with the SPI enabled ignores bit 2:
  - Master mode: pad 2 drives `spi_sck_out` and `spi_sck_in` is 0.
  - Slave mode: pad 2 is undriven and `spi_sck_in` follows it.
- R6: Slave-select with the SPI enabled:
  - Master mode with bit 3 at 1: the pin is GPIO.
  - Master mode with bit 3 at 0: the pin is undriven.
  - Slave mode: the pin is undriven. `spi_ss_n_in` follows pad 3 when bit 3 is 0 and is 1 when bit 3 is 1.
  - In every other case `spi_ss_n_in` is 1.
- R7: `mode_fault` is set on a clock edge where the SPI is enabled, in master mode, with bit 3 at 0 and pad 3 low. It then stays set until an edge with `mode_fault_clr`=1. If a set and a clear fall on the same edge, the set wins.
- R8: An SCI receive pin (4 or 6) feeds its channel's receive input only when its direction bit is 1 and that channel's receiver enable is 1. Otherwise the pin is GPIO and the receive input is held at 1.
- R9: An SCI transmit pin (5 or 7) drives its channel's transmit data only when its direction bit is 1 and that channel's transmitter enable is 1. Otherwise the pin is GPIO.
- R10: With `spi_en`=0, pins 0 to 3 are GPIO, and all SPI inputs sit idle (0, with slave-select at 1).
- R11: A GPIO pin drives `pad_oe` equal to its direction bit and `pad_out` equal to its latch bit. Reading slot 1 returns the latch bit for GPIO pins whose direction bit is 1, and the live pad level for every other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write enable |
| bus_sel | input | 1 | 0 = direction register, 1 = data latch |
| bus_be | input | 2 | Byte strobes, bit 0 = low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected slot |
| spi_en | input | 1 | SPI enable |
| spi_master | input | 1 | 1 = SPI master mode |
| sci_a_rx_en | input | 1 | SCI-A receiver enable |
| sci_a_tx_en | input | 1 | SCI-A transmitter enable |
| sci_b_rx_en | input | 1 | SCI-B receiver enable |
| sci_b_tx_en | input | 1 | SCI-B transmitter enable |
| spi_miso_out | input | 1 | Slave serial data from the SPI |
| spi_mosi_out | input | 1 | Master serial data from the SPI |
| spi_sck_out | input | 1 | Master clock from the SPI |
| sci_a_txd | input | 1 | SCI-A transmit data |
| sci_b_txd | input | 1 | SCI-B transmit data |
| spi_miso_in | output | 1 | Serial data into the SPI (master) |
| spi_mosi_in | output | 1 | Serial data into the SPI (slave) |
| spi_sck_in | output | 1 | Clock into the SPI (slave) |
| spi_ss_n_in | output | 1 | Slave-select into the SPI, active low |
| sci_a_rxd | output | 1 | SCI-A receive data |
| sci_b_rxd | output | 1 | SCI-B receive data |
| mode_fault | output | 1 | Sticky SPI mode-fault flag |
| mode_fault_clr | input | 1 | Clear strobe for the mode-fault flag |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The properties assume that the mode and enable inputs, the pad levels and the bus inputs are stable around each rising clock edge. They also assume these inputs never carry X or Z after reset. The bench meets this by changing every input only at the falling edge, always to a fully defined random value. Because it picks the pad levels and the slave-select level at random, with the clear strobe firing about one cycle in four, the mode-fault flag is set, held and cleared many times, including on edges where a set and a clear coincide.

// File: rtl/port_mux_pkg.sv
package port_mux_pkg;
  localparam int PORT_W   = 8;
  localparam int BUS_W    = 16;
  localparam int LANES    = BUS_W / 8;
  localparam int SCI_CH   = 2;
  localparam int SPI_PINS = 4;

  localparam int PIN_MISO = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_SCK  = 2;
  localparam int PIN_SS   = 3;
  localparam int PIN_SCI0 = 4;

  // Pick bits from a where sel is 1, from b elsewhere.
  function automatic logic [PORT_W-1:0] pick_bits(input logic [PORT_W-1:0] sel,
                                                  input logic [PORT_W-1:0] a,
                                                  input logic [PORT_W-1:0] b);
    return (sel & a) | (~sel & b);
  endfunction

  // GPIO readback: latch for GPIO outputs, live pad level otherwise.
  function automatic logic [PORT_W-1:0] gpio_readback(input logic [PORT_W-1:0] gpio,
                                                      input logic [PORT_W-1:0] dir,
                                                      input logic [PORT_W-1:0] latch,
                                                      input logic [PORT_W-1:0] pad);
    return pick_bits(gpio & dir, latch, pad);
  endfunction

  // Low-lane write hit for a given slot.
  function automatic logic low_lane_hit(input logic we, input logic sel,
                                        input logic slot, input logic be0);
    return we & (sel == slot) & be0;
  endfunction
endpackage

// File: rtl/port_dir_regs.sv
module port_dir_regs
  import port_mux_pkg::*;
#(
  parameter int DATA_W = PORT_W,
  parameter int BW     = BUS_W,
  localparam int NBE   = BW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_sel,
  input  logic [NBE-1:0]    bus_be,
  input  logic [BW-1:0]     bus_wdata,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] latch_q
);
  logic dir_wr, latch_wr;
  assign dir_wr   = low_lane_hit(bus_we, bus_sel, 1'b0, bus_be[0]);
  assign latch_wr = low_lane_hit(bus_we, bus_sel, 1'b1, bus_be[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
    end else begin
      if (dir_wr)   dir_q   <= bus_wdata[DATA_W-1:0];
      if (latch_wr) latch_q <= bus_wdata[DATA_W-1:0];
    end
  end

  // R2: the direction register moves only on a low-lane write to slot 0
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && !bus_sel && bus_be[0]) |=> $stable(dir_q));
  // R2: the latch moves only on a low-lane write to slot 1
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_sel && bus_be[0]) |=> $stable(latch_q));
endmodule

// File: rtl/port_pin_decode.sv
module port_pin_decode
  import port_mux_pkg::*;
#(
  parameter int NCH = SCI_CH
) (
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic [NCH-1:0]    sci_rx_en,
  input  logic [NCH-1:0]    sci_tx_en,
  input  logic [NCH-1:0]    sci_txd,
  input  logic              spi_miso_out,
  input  logic              spi_mosi_out,
  input  logic              spi_sck_out,
  input  logic [PORT_W-1:0] dir,
  input  logic [PORT_W-1:0] pad,
  output logic [PORT_W-1:0] gpio_sel,
  output logic [PORT_W-1:0] periph_oe,
  output logic [PORT_W-1:0] periph_out,
  output logic              spi_miso_in,
  output logic              spi_mosi_in,
  output logic              spi_sck_in,
  output logic              spi_ss_n_in,
  output logic [NCH-1:0]    sci_rxd,
  output logic              fault_arm
);
  localparam int SCI_PINS = 2 * NCH;

  logic [SPI_PINS-1:0] spi_gpio, spi_oe, spi_out;
  logic [SCI_PINS-1:0] sci_gpio, sci_oe, sci_out;

  // SPI group: pins 0..3
  always_comb begin
    spi_gpio    = '1;
    spi_oe      = '0;
    spi_out     = '0;
    spi_miso_in = 1'b0;
    spi_mosi_in = 1'b0;
    spi_sck_in  = 1'b0;
    spi_ss_n_in = 1'b1;
    if (spi_en) begin
      spi_gpio[PIN_MISO] = 1'b0;
      spi_gpio[PIN_MOSI] = 1'b0;
      spi_gpio[PIN_SCK]  = 1'b0;
      if (spi_master) begin
        spi_miso_in       = ~dir[PIN_MISO] & pad[PIN_MISO];
        spi_oe[PIN_MOSI]  = dir[PIN_MOSI];
        spi_out[PIN_MOSI] = spi_mosi_out;
        spi_oe[PIN_SCK]   = 1'b1;
        spi_out[PIN_SCK]  = spi_sck_out;
        spi_gpio[PIN_SS]  = dir[PIN_SS];
      end else begin
        spi_oe[PIN_MISO]  = dir[PIN_MISO];
        spi_out[PIN_MISO] = spi_miso_out;
        spi_mosi_in       = ~dir[PIN_MOSI] & pad[PIN_MOSI];
        spi_sck_in        = pad[PIN_SCK];
        spi_gpio[PIN_SS]  = 1'b0;
        spi_ss_n_in       = dir[PIN_SS] | pad[PIN_SS];
      end
    end
  end

  assign fault_arm = spi_en & spi_master & ~dir[PIN_SS];

  // SCI group: one receive/transmit pin pair per channel
  for (genvar ch = 0; ch < NCH; ch++) begin : g_sci
    localparam int RX = PIN_SCI0 + 2 * ch;
    localparam int TX = RX + 1;
    logic rx_route, tx_route;
    assign rx_route = dir[RX] & sci_rx_en[ch];
    assign tx_route = dir[TX] & sci_tx_en[ch];

    assign sci_gpio[2*ch]     = ~rx_route;
    assign sci_oe[2*ch]       = 1'b0;
    assign sci_out[2*ch]      = 1'b0;
    assign sci_rxd[ch]        = rx_route ? pad[RX] : 1'b1;

    assign sci_gpio[2*ch + 1] = ~tx_route;
    assign sci_oe[2*ch + 1]   = tx_route;
    assign sci_out[2*ch + 1]  = sci_txd[ch];
  end

  assign gpio_sel   = {sci_gpio, spi_gpio};
  assign periph_oe  = {sci_oe, spi_oe};
  assign periph_out = {sci_out, spi_out};
endmodule

// File: rtl/port_mode_fault.sv
module port_mode_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_arm,
  input  logic ss_pad,
  input  logic fault_clr,
  output logic mode_fault
);
  logic fault_evt;
  assign fault_evt = fault_arm & ~ss_pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_fault <= 1'b0;
    else if (fault_evt) mode_fault <= 1'b1;
    else if (fault_clr) mode_fault <= 1'b0;
  end

  // R7: a detected fault shows up on the next cycle, even with a clear
  p_fault_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> mode_fault);
  // R7: the flag stays set until a clear strobe
  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault && !fault_clr |=> mode_fault);
  // R7: without a fault event the flag never rises
  p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_evt |=> !$rose(mode_fault));
endmodule

// File: rtl/shared_port_mux.sv
module shared_port_mux
  import port_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_sel,
  input  logic [LANES-1:0]  bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic              sci_a_rx_en,
  input  logic              sci_a_tx_en,
  input  logic              sci_b_rx_en,
  input  logic              sci_b_tx_en,
  input  logic              spi_miso_out,
  input  logic              spi_mosi_out,
  input  logic              spi_sck_out,
  input  logic              sci_a_txd,
  input  logic              sci_b_txd,
  output logic              spi_miso_in,
  output logic              spi_mosi_in,
  output logic              spi_sck_in,
  output logic              spi_ss_n_in,
  output logic              sci_a_rxd,
  output logic              sci_b_rxd,
  output logic              mode_fault,
  input  logic              mode_fault_clr,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe
);
  localparam int PAD_HI = BUS_W - PORT_W;

  logic [PORT_W-1:0] dir_q, latch_q;
  logic [PORT_W-1:0] gpio_sel, periph_oe, periph_out;
  logic [SCI_CH-1:0] sci_rxd;
  logic              fault_arm;

  port_dir_regs #(.DATA_W(PORT_W), .BW(BUS_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .dir_q     (dir_q),
    .latch_q   (latch_q)
  );

  // channel 0 = SCI-B (pins 4,5), channel 1 = SCI-A (pins 6,7)
  port_pin_decode #(.NCH(SCI_CH)) u_decode (
    .spi_en       (spi_en),
    .spi_master   (spi_master),
    .sci_rx_en    ({sci_a_rx_en, sci_b_rx_en}),
    .sci_tx_en    ({sci_a_tx_en, sci_b_tx_en}),
    .sci_txd      ({sci_a_txd, sci_b_txd}),
    .spi_miso_out (spi_miso_out),
    .spi_mosi_out (spi_mosi_out),
    .spi_sck_out  (spi_sck_out),
    .dir          (dir_q),
    .pad          (pad_in),
    .gpio_sel     (gpio_sel),
    .periph_oe    (periph_oe),
    .periph_out   (periph_out),
    .spi_miso_in  (spi_miso_in),
    .spi_mosi_in  (spi_mosi_in),
    .spi_sck_in   (spi_sck_in),
    .spi_ss_n_in  (spi_ss_n_in),
    .sci_rxd      (sci_rxd),
    .fault_arm    (fault_arm)
  );

  assign sci_b_rxd = sci_rxd[0];
  assign sci_a_rxd = sci_rxd[1];

  port_mode_fault u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_arm  (fault_arm),
    .ss_pad     (pad_in[PIN_SS]),
    .fault_clr  (mode_fault_clr),
    .mode_fault (mode_fault)
  );

  assign pad_oe  = pick_bits(gpio_sel, dir_q, periph_oe);
  assign pad_out = pick_bits(gpio_sel, latch_q, periph_out);

  assign bus_rdata = bus_sel
    ? {{PAD_HI{1'b0}}, gpio_readback(gpio_sel, dir_q, latch_q, pad_in)}
    : {{PAD_HI{1'b0}}, dir_q};

  // R5: an enabled master always drives its clock pad
  p_sck_master_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en && spi_master |-> pad_oe[PIN_SCK] && pad_out[PIN_SCK] == spi_sck_out);
  // R6: a pin armed for fault detection is never driven
  p_ss_fault_undriven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_arm |-> !pad_oe[PIN_SS]);
  // R8: a routed receive pin is never driven
  p_sci_rx_undriven_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sci_a_rxd || !sci_b_rxd |-> !(pad_oe[4] && !sci_b_rxd) && !(pad_oe[6] && !sci_a_rxd));
  // R10: with the SPI off its pins follow the direction bits
  p_spi_off_gpio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_en |-> pad_oe[3:0] == dir_q[3:0] && spi_ss_n_in && !spi_sck_in);
endmodule

// File: tb/test_shared_port_mux.sv
`timescale 1ns/1ps
module test_shared_port_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 0, bus_sel = 0;
  logic [1:0]  bus_be = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic        spi_en = 0, spi_master = 0;
  logic        sci_a_rx_en = 0, sci_a_tx_en = 0, sci_b_rx_en = 0, sci_b_tx_en = 0;
  logic        spi_miso_out = 0, spi_mosi_out = 0, spi_sck_out = 0, sci_a_txd = 0, sci_b_txd = 0;
  logic        spi_miso_in, spi_mosi_in, spi_sck_in, spi_ss_n_in, sci_a_rxd, sci_b_rxd;
  logic        mode_fault, mode_fault_clr = 0;
  logic [7:0]  pad_in = 0, pad_out, pad_oe;

  int checks = 0, failures = 0;

  // model state
  logic [7:0] m_dir = 0, m_lat = 0;
  logic       m_fault = 0;
  // expected outputs
  logic [7:0] e_oe, e_out, e_gpio;
  logic       e_miso, e_mosi, e_sck, e_ssn, e_rxa, e_rxb;

  always #2.5 clk = ~clk;

  shared_port_mux i_shared_port_mux (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model();
    e_gpio = 8'hFF; e_oe = 0; e_out = 0;
    e_miso = 0; e_mosi = 0; e_sck = 0; e_ssn = 1;
    if (spi_en && spi_master) begin
      e_gpio[2:0] = 0;
      if (!m_dir[0]) e_miso = pad_in[0];
      if (m_dir[1]) begin e_oe[1] = 1; e_out[1] = spi_mosi_out; end
      e_oe[2] = 1; e_out[2] = spi_sck_out;
      e_gpio[3] = m_dir[3];
    end else if (spi_en) begin
      e_gpio[3:0] = 0;
      if (m_dir[0]) begin e_oe[0] = 1; e_out[0] = spi_miso_out; end
      if (!m_dir[1]) e_mosi = pad_in[1];
      e_sck = pad_in[2];
      e_ssn = m_dir[3] ? 1'b1 : pad_in[3];
    end
    e_rxb = 1; e_rxa = 1;
    if (m_dir[4] && sci_b_rx_en) begin e_gpio[4] = 0; e_rxb = pad_in[4]; end
    if (m_dir[6] && sci_a_rx_en) begin e_gpio[6] = 0; e_rxa = pad_in[6]; end
    if (m_dir[5] && sci_b_tx_en) begin e_gpio[5] = 0; e_oe[5] = 1; e_out[5] = sci_b_txd; end
    if (m_dir[7] && sci_a_tx_en) begin e_gpio[7] = 0; e_oe[7] = 1; e_out[7] = sci_a_txd; end
    for (int i = 0; i < 8; i++)
      if (e_gpio[i]) begin e_oe[i] = m_dir[i]; e_out[i] = m_lat[i]; end
  endtask

  // Compare now, then advance the model across the next rising edge.
  task automatic step();
    logic [7:0] rd;
    #1;
    model();
    check("R3 spi_miso_in", spi_miso_in, e_miso);
    check("R4 spi_mosi_in", spi_mosi_in, e_mosi);
    check("R5 spi_sck_in", spi_sck_in, e_sck);
    check("R6 spi_ss_n_in", spi_ss_n_in, e_ssn);
    check("R8 sci rxd", {sci_a_rxd, sci_b_rxd}, {e_rxa, e_rxb});
    check("R9/R11 pad_oe", pad_oe, e_oe);
    check("R9/R11 pad_out", pad_out & e_oe, e_out & e_oe);
    for (int i = 0; i < 8; i++) rd[i] = (e_gpio[i] && m_dir[i]) ? m_lat[i] : pad_in[i];
    check("R2/R11 readback", bus_rdata, bus_sel ? {8'h00, rd} : {8'h00, m_dir});
    check("R7 mode_fault", mode_fault, m_fault);
    if (spi_en && spi_master && !m_dir[3] && !pad_in[3]) m_fault = 1;
    else if (mode_fault_clr) m_fault = 0;
    if (bus_we && bus_be[0]) begin
      if (bus_sel) m_lat = bus_wdata[7:0]; else m_dir = bus_wdata[7:0];
    end
  endtask

  task automatic idle_bus();
    bus_we = 0; bus_be = 0; mode_fault_clr = 0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 mode_fault", mode_fault, 1'b0);
    check("R1 dir read", bus_rdata, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    step();

    // R2: upper-lane-only write is ignored
    @(negedge clk);
    bus_we = 1; bus_sel = 0; bus_be = 2'b10; bus_wdata = 16'hFFFF;
    step();
    @(negedge clk); idle_bus();
    step();
    check("R2 upper write ignored", bus_rdata, 16'h0000);

    // R2: low-lane write lands, upper byte reads zero
    @(negedge clk);
    bus_we = 1; bus_sel = 0; bus_be = 2'b11; bus_wdata = 16'hA5F0;
    step();
    @(negedge clk); idle_bus();
    step();
    check("R2 low write", bus_rdata, 16'h00F0);

    // R10: SPI off, pins 0..3 GPIO (dir 0xF0 -> low nibble inputs)
    @(negedge clk); spi_en = 0; pad_in = 8'h0F;
    step();
    check("R10 spi pins undriven", pad_oe[3:0], 4'h0);

    // R7: directed fault, then simultaneous set and clear, then clear
    @(negedge clk);
    bus_we = 1; bus_sel = 0; bus_be = 2'b01; bus_wdata = 16'h0000;
    step();
    @(negedge clk); idle_bus(); spi_en = 1; spi_master = 1; pad_in = 8'h00;
    step();
    @(negedge clk); mode_fault_clr = 1;
    step();
    @(negedge clk); pad_in = 8'hFF;
    step();
    check("R7 set wins over clear", mode_fault, 1'b1);
    @(negedge clk); mode_fault_clr = 0;
    step();
    check("R7 cleared", mode_fault, 1'b0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      bus_we = ($urandom % 3) == 0;
      bus_sel = $urandom;
      bus_be = $urandom;
      bus_wdata = $urandom;
      spi_en = ($urandom % 4) != 0;
      spi_master = $urandom;
      {sci_a_rx_en, sci_a_tx_en, sci_b_rx_en, sci_b_tx_en} = $urandom;
      {spi_miso_out, spi_mosi_out, spi_sck_out, sci_a_txd, sci_b_txd} = $urandom;
      pad_in = $urandom;
      if (($urandom % 3) != 0) pad_in[3] = 1'b1;
      mode_fault_clr = ($urandom % 4) == 0;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule